// File: doc/BRIEF.md
# Spin-Lock Polling Loop Detector

This block sits beside the execute stage of a multithreaded pipeline. Each cycle it looks at the instruction that is in execute and holds a small pattern counter for every hardware context. It uses these to recognise a spin-lock polling loop. The loop has four instructions in a fixed order:

- a load-type instruction (an atomic test-and-set, an atomic swap or a plain load) that fetches the lock word into a register;
- a compare of that register against zero that sets the condition codes;
- a branch-if-not-equal back to the load;
- a nop in the delay slot.

The loop is detected when its load comes round a second time. At that point the block issues a compact synchronisation request to the memory side and stops the thread from spinning in the pipeline. The request carries the context, its register window, the destination register and a tag for the lock address. In the same cycle the block marks the context as waiting and raises a context-switch request.

An external decoder supplies the instruction class, the register numbers and the address tag. Memory access is handled outside this block. So are clearing the wait flag and writing zero into the register when the lock is later observed free. Each context has an enable bit that controls whether detection in that context may produce any output.

Top module: `spinloop_detector`

## Requirements
- R1: While reset is high and in the first cycle after it falls, sync_valid, set_wait and switch_req are all zero, and every context's pattern counter starts at 0.
- R2: A valid instruction of class 1 (load-type) in execute sets its context's counter to 1 and captures its destination register and address tag. The exception is a load that finds the counter at 4 with the same register and tag as the captured ones (see R5).
- R3: In pattern order the counter advances by one. A class 2 instruction (test against zero) advances 1 to 2, but only if its source register equals the captured destination register. Class 3 (branch-not-equal back) advances 2 to 3. Class 4 (nop) advances 3 to 4.
- R4: Any other valid instruction of a context clears that context's counter to 0. This covers class 0, classes 5 to 7, a pattern class met at the wrong count, and a test of a different register.
- R5: A class 1 instruction that finds the counter at 4 with matching register and tag completes the loop, and the counter returns to 0. The next cycle, sync_valid pulses for one cycle and carries that instruction's context, window, destination register and tag. A load with a different register or tag instead restarts the counter at 1.
- R6: In the cycle of sync_valid, set_wait has exactly the bit of the reported context set and switch_req is high. Both are zero in every other cycle.
- R7: Each context has its own counter. Instructions of one context never change another context's counter, so loops in different contexts may interleave freely.
- R8: A cycle with ex_valid low leaves every counter unchanged, whatever the other inputs carry.
- R9: When a context's ctx_en bit is 0, a completed loop produces no sync_valid, set_wait or switch_req. Its counter is still cleared to 0.

Each pattern counter runs through these values, and the loop is reported on the step from 4:

| Counter | Meaning |
|---|---|
| 0 | idle |
| 1 | after the load |
| 2 | after the test against zero |
| 3 | after the branch back |
| 4 | after the delay-slot nop |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | An unannulled instruction is in execute |
| ex_ctx | input | CTX_W | Context of the instruction in execute |
| ex_cls | input | 3 | Instruction class: 0 other, 1 load-type, 2 test-zero, 3 branch back, 4 nop |
| ex_src | input | REG_W | Source register of the test-zero instruction |
| ex_rd | input | REG_W | Destination register of the load-type instruction |
| ex_win | input | WIN_W | Register window of the instruction |
| ex_tag | input | TAG_W | Lock address tag of the load-type instruction |
| ctx_en | input | NUM_CTX | Per-context enable of loop-triggered switching |
| sync_valid | output | 1 | One-cycle synchronisation request |
| sync_ctx | output | CTX_W | Context of the request |
| sync_win | output | WIN_W | Register window of the request |
| sync_rd | output | REG_W | Destination register of the request |
| sync_tag | output | TAG_W | Lock address tag of the request |
| set_wait | output | NUM_CTX | One-hot strobe that marks a context as waiting |
| switch_req | output | 1 | Context-switch request |

## Verification
The bench sweeps every context and corrupts each of the four loop positions in turn. A detector that counted loose instructions rather than the exact order would fire on a damaged first pass. One that failed to clear on a stray instruction would fire one pass early when the loop is then resumed. The bench also changes the tag and the register of the second load, and tests a different register. A design that ignored these fields would treat unrelated loads as the same lock.

Other cases target shared state and enabling. Interleaving two contexts and adding bubbles would expose a shared counter or an update on invalid cycles, since either would merge or advance the patterns. Running a loop in a disabled context, then enabling it, shows whether the counter is still cleared at detection. A design that kept the count would fire on the very next load.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [2:0] {
        IC_OTHER  = 3'd0,
        IC_LOAD   = 3'd1,
        IC_TEST   = 3'd2,
        IC_BRANCH = 3'd3,
        IC_NOP    = 3'd4
    } iclass_e;

    typedef logic [2:0] pcount_t;

    localparam pcount_t CNT_IDLE   = 3'd0;
    localparam pcount_t CNT_LOADED = 3'd1;
    localparam pcount_t CNT_TESTED = 3'd2;
    localparam pcount_t CNT_BRANCH = 3'd3;
    localparam pcount_t CNT_ARMED  = 3'd4;

    // Step for the three non-load pattern members; anything out of place clears.
    function automatic pcount_t follow_step(iclass_e cls, pcount_t cur, logic src_ok);
        pcount_t nxt;
        nxt = CNT_IDLE;
        case (cls)
            IC_TEST:   if (cur == CNT_LOADED && src_ok) nxt = CNT_TESTED;
            IC_BRANCH: if (cur == CNT_TESTED) nxt = CNT_BRANCH;
            IC_NOP:    if (cur == CNT_BRANCH) nxt = CNT_ARMED;
            default:   nxt = CNT_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/spin_ctx_track.sv
module spin_ctx_track
    import spin_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  iclass_e          cls,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] rd,
    input  logic [TAG_W-1:0] tag,
    output logic             fire
);

    pcount_t          cnt;
    logic [REG_W-1:0] held_rd;
    logic [TAG_W-1:0] held_tag;

    always_comb begin
        fire = hit && (cls == IC_LOAD) && (cnt == CNT_ARMED)
               && (rd == held_rd) && (tag == held_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= CNT_IDLE;
            held_rd  <= '0;
            held_tag <= '0;
        end else if (hit) begin
            if (cls == IC_LOAD) begin
                if (fire) begin
                    cnt <= CNT_IDLE;
                end else begin
                    cnt      <= CNT_LOADED;
                    held_rd  <= rd;
                    held_tag <= tag;
                end
            end else begin
                cnt <= follow_step(cls, cnt, src == held_rd);
            end
        end
    end

endmodule

// File: rtl/spin_req_reg.sv
module spin_req_reg #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2,
    parameter int WIN_W   = 5,
    parameter int REG_W   = 5,
    parameter int TAG_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTX-1:0] fire_en,
    input  logic [CTX_W-1:0]   ctx,
    input  logic [WIN_W-1:0]   win,
    input  logic [REG_W-1:0]   rd,
    input  logic [TAG_W-1:0]   tag,
    output logic               req_valid,
    output logic [CTX_W-1:0]   req_ctx,
    output logic [WIN_W-1:0]   req_win,
    output logic [REG_W-1:0]   req_rd,
    output logic [TAG_W-1:0]   req_tag,
    output logic [NUM_CTX-1:0] wait_set,
    output logic               sw_req
);

    logic any_fire;
    assign any_fire = |fire_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_ctx   <= '0;
            req_win   <= '0;
            req_rd    <= '0;
            req_tag   <= '0;
            wait_set  <= '0;
            sw_req    <= 1'b0;
        end else begin
            req_valid <= any_fire;
            wait_set  <= fire_en;
            sw_req    <= any_fire;
            if (any_fire) begin
                req_ctx <= ctx;
                req_win <= win;
                req_rd  <= rd;
                req_tag <= tag;
            end
        end
    end

endmodule

// File: rtl/spinloop_detector.sv
module spinloop_detector
    import spin_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int WIN_W   = 5,
    parameter int REG_W   = 5,
    parameter int TAG_W   = 8,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ex_valid,
    input  logic [CTX_W-1:0]   ex_ctx,
    input  logic [2:0]         ex_cls,
    input  logic [REG_W-1:0]   ex_src,
    input  logic [REG_W-1:0]   ex_rd,
    input  logic [WIN_W-1:0]   ex_win,
    input  logic [TAG_W-1:0]   ex_tag,
    input  logic [NUM_CTX-1:0] ctx_en,
    output logic               sync_valid,
    output logic [CTX_W-1:0]   sync_ctx,
    output logic [WIN_W-1:0]   sync_win,
    output logic [REG_W-1:0]   sync_rd,
    output logic [TAG_W-1:0]   sync_tag,
    output logic [NUM_CTX-1:0] set_wait,
    output logic               switch_req
);

    iclass_e            cls;
    logic [NUM_CTX-1:0] hit;
    logic [NUM_CTX-1:0] fire;
    logic [NUM_CTX-1:0] fire_en;

    assign cls     = iclass_e'(ex_cls);
    assign fire_en = fire & ctx_en;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assign hit[c] = ex_valid && (ex_ctx == CTX_W'(c));

        spin_ctx_track #(
            .REG_W(REG_W),
            .TAG_W(TAG_W)
        ) track_i (
            .clk (clk),
            .rst (rst),
            .hit (hit[c]),
            .cls (cls),
            .src (ex_src),
            .rd  (ex_rd),
            .tag (ex_tag),
            .fire(fire[c])
        );
    end

    spin_req_reg #(
        .NUM_CTX(NUM_CTX),
        .CTX_W  (CTX_W),
        .WIN_W  (WIN_W),
        .REG_W  (REG_W),
        .TAG_W  (TAG_W)
    ) out_i (
        .clk      (clk),
        .rst      (rst),
        .fire_en  (fire_en),
        .ctx      (ex_ctx),
        .win      (ex_win),
        .rd       (ex_rd),
        .tag      (ex_tag),
        .req_valid(sync_valid),
        .req_ctx  (sync_ctx),
        .req_win  (sync_win),
        .req_rd   (sync_rd),
        .req_tag  (sync_tag),
        .wait_set (set_wait),
        .sw_req   (switch_req)
    );

endmodule

// File: rtl/spinloop_detector_chk.sv
module spinloop_detector_chk #(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2,
    parameter int REG_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               ex_valid,
    input logic [CTX_W-1:0]   ex_ctx,
    input logic [2:0]         ex_cls,
    input logic [REG_W-1:0]   ex_rd,
    input logic [NUM_CTX-1:0] ctx_en,
    input logic               sync_valid,
    input logic [CTX_W-1:0]   sync_ctx,
    input logic [REG_W-1:0]   sync_rd,
    input logic [NUM_CTX-1:0] set_wait,
    input logic               switch_req
);

    AST_REQ_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> $past(ex_valid) && ($past(ex_cls) == 3'd1)); // R5

    AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> (sync_ctx == $past(ex_ctx)) && (sync_rd == $past(ex_rd))); // R5

    AST_NO_REQ_ON_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |=> !sync_valid); // R8

    AST_WAIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_wait)); // R6

    AST_WAIT_MATCH: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> switch_req && (set_wait == (NUM_CTX'(1) << sync_ctx))); // R6

    AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !sync_valid |-> !switch_req && (set_wait == '0)); // R6

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> $past(ctx_en[ex_ctx])); // R9

endmodule

bind spinloop_detector spinloop_detector_chk #(
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W),
    .REG_W  (REG_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ex_valid  (ex_valid),
    .ex_ctx    (ex_ctx),
    .ex_cls    (ex_cls),
    .ex_rd     (ex_rd),
    .ctx_en    (ctx_en),
    .sync_valid(sync_valid),
    .sync_ctx  (sync_ctx),
    .sync_rd   (sync_rd),
    .set_wait  (set_wait),
    .switch_req(switch_req)
);

// File: tb/spinloop_detector_tb_top.sv
module spinloop_detector_tb_top;

    localparam int NCTX = 4;
    localparam int CW   = 2;
    localparam int WW   = 5;
    localparam int RW   = 5;
    localparam int TW   = 8;

    localparam logic [2:0] K_OTH = 3'd0;
    localparam logic [2:0] K_LD  = 3'd1;
    localparam logic [2:0] K_TST = 3'd2;
    localparam logic [2:0] K_BR  = 3'd3;
    localparam logic [2:0] K_NOP = 3'd4;

    logic            clk = 1'b0;
    logic            rst;
    logic            ex_valid;
    logic [CW-1:0]   ex_ctx;
    logic [2:0]      ex_cls;
    logic [RW-1:0]   ex_src;
    logic [RW-1:0]   ex_rd;
    logic [WW-1:0]   ex_win;
    logic [TW-1:0]   ex_tag;
    logic [NCTX-1:0] ctx_en;
    logic            sync_valid;
    logic [CW-1:0]   sync_ctx;
    logic [WW-1:0]   sync_win;
    logic [RW-1:0]   sync_rd;
    logic [TW-1:0]   sync_tag;
    logic [NCTX-1:0] set_wait;
    logic            switch_req;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    spinloop_detector #(
        .NUM_CTX(NCTX), .WIN_W(WW), .REG_W(RW), .TAG_W(TW)
    ) dut_i (
        .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_ctx(ex_ctx),
        .ex_cls(ex_cls), .ex_src(ex_src), .ex_rd(ex_rd), .ex_win(ex_win),
        .ex_tag(ex_tag), .ctx_en(ctx_en), .sync_valid(sync_valid),
        .sync_ctx(sync_ctx), .sync_win(sync_win), .sync_rd(sync_rd),
        .sync_tag(sync_tag), .set_wait(set_wait), .switch_req(switch_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one execute-stage slot; outputs are sampled one negedge later.
    task automatic issue(input bit v, input int c, input logic [2:0] k,
                         input int src, input int rd, input int tag, input int win);
        ex_valid = v;
        ex_ctx   = CW'(c);
        ex_cls   = k;
        ex_src   = RW'(src);
        ex_rd    = RW'(rd);
        ex_tag   = TW'(tag);
        ex_win   = WW'(win);
        @(negedge clk);
    endtask

    task automatic expect_quiet(input string req);
        chk(sync_valid == 1'b0, req, "sync_valid", int'(sync_valid), 0);
        chk(set_wait == '0, req, "set_wait", int'(set_wait), 0);
        chk(switch_req == 1'b0, req, "switch_req", int'(switch_req), 0);
    endtask

    task automatic expect_req(input string req, input int c, input int rd,
                              input int tag, input int win);
        chk(sync_valid == 1'b1, req, "sync_valid", int'(sync_valid), 1);
        chk(int'(sync_ctx) == c, req, "sync_ctx", int'(sync_ctx), c);
        chk(int'(sync_rd) == rd, req, "sync_rd", int'(sync_rd), rd);
        chk(int'(sync_tag) == tag, req, "sync_tag", int'(sync_tag), tag);
        chk(int'(sync_win) == win, req, "sync_win", int'(sync_win), win);
        chk(int'(set_wait) == (1 << c), req, "set_wait", int'(set_wait), 1 << c);
        chk(switch_req == 1'b1, req, "switch_req", int'(switch_req), 1);
    endtask

    // Test, branch, nop of a pass, with no request expected after any of them.
    task automatic tail(input int c, input int rd, input string req);
        issue(1, c, K_TST, rd, 0, 0, c); expect_quiet(req);
        issue(1, c, K_BR,  0,  0, 0, c); expect_quiet(req);
        issue(1, c, K_NOP, 0,  0, 0, c); expect_quiet(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1;
        ctx_en = '1;
        ex_valid = 1'b0; ex_ctx = '0; ex_cls = '0; ex_src = '0;
        ex_rd = '0; ex_win = '0; ex_tag = '0;
        repeat (3) @(negedge clk);
        expect_quiet("R1");
        rst = 1'b0;
        issue(0, 0, K_OTH, 0, 0, 0, 0);
        expect_quiet("R1");

        // R2 R3 R5 R6: every context, two passes, request on the second load.
        for (int c = 0; c < NCTX; c++) begin
            issue(1, c, K_LD, 0, 3 + c, 16 * c + 5, c); expect_quiet("R2");
            tail(c, 3 + c, "R3");
            issue(1, c, K_LD, 0, 3 + c, 16 * c + 5, c);
            expect_req("R5", c, 3 + c, 16 * c + 5, c);
            issue(1, c, K_OTH, 0, 0, 0, c); expect_quiet("R6");
            // Counter was cleared: the next load restarts, no early request.
            issue(1, c, K_LD, 0, 3 + c, 16 * c + 5, c); expect_quiet("R5");
            tail(c, 3 + c, "R5");
            issue(1, c, K_LD, 0, 3 + c, 16 * c + 5, c);
            expect_req("R5", c, 3 + c, 16 * c + 5, c);
        end

        // R4: corrupt each position of the first pass, then resume the loop.
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 4; p++) begin
                logic [2:0] cl;
                cl = (p == 0) ? K_LD : (p == 1) ? K_TST : (p == 2) ? K_BR : K_NOP;
                if (p == k) cl = K_OTH;
                issue(1, 1, cl, 9, 9, 42, 1); expect_quiet("R4");
            end
            issue(1, 1, K_LD, 0, 9, 42, 1); expect_quiet("R4");
            tail(1, 9, "R4");
            issue(1, 1, K_LD, 0, 9, 42, 1); expect_req("R4", 1, 9, 42, 1);
        end

        // R4: wrong order, unknown class and test of another register.
        issue(1, 2, K_LD, 0, 7, 11, 2); expect_quiet("R4");
        issue(1, 2, K_BR, 0, 0, 0, 2);  expect_quiet("R4");
        issue(1, 2, K_TST, 7, 0, 0, 2); expect_quiet("R4");
        issue(1, 2, K_NOP, 0, 0, 0, 2); expect_quiet("R4");
        issue(1, 2, K_LD, 0, 7, 11, 2); expect_quiet("R4");
        issue(1, 2, K_TST, 8, 0, 0, 2); expect_quiet("R4");
        issue(1, 2, K_BR, 0, 0, 0, 2);  expect_quiet("R4");
        issue(1, 2, K_NOP, 0, 0, 0, 2); expect_quiet("R4");
        issue(1, 2, K_LD, 0, 7, 11, 2); expect_quiet("R4");
        issue(1, 2, 3'd6, 0, 0, 0, 2);  expect_quiet("R4");
        tail(2, 7, "R4");
        issue(1, 2, K_LD, 0, 7, 11, 2); expect_quiet("R4");

        // R5: second load with another tag or register restarts at 1.
        issue(1, 3, K_LD, 0, 4, 20, 3); expect_quiet("R5");
        tail(3, 4, "R5");
        issue(1, 3, K_LD, 0, 4, 21, 3); expect_quiet("R5");
        tail(3, 4, "R5");
        issue(1, 3, K_LD, 0, 5, 21, 3); expect_quiet("R5");
        tail(3, 5, "R5");
        issue(1, 3, K_LD, 0, 5, 21, 3); expect_req("R5", 3, 5, 21, 3);

        // R7: two contexts interleaved, requests on consecutive cycles.
        for (int pass = 0; pass < 2; pass++) begin
            issue(1, 0, K_LD, 0, 12, 100, 6);
            if (pass == 0) expect_quiet("R7");
            else expect_req("R7", 0, 12, 100, 6);
            issue(1, 1, K_LD, 0, 13, 101, 7);
            if (pass == 0) expect_quiet("R7");
            else expect_req("R7", 1, 13, 101, 7);
            if (pass == 0) begin
                issue(1, 0, K_TST, 12, 0, 0, 6); expect_quiet("R7");
                issue(1, 1, K_TST, 13, 0, 0, 7); expect_quiet("R7");
                issue(1, 0, K_BR, 0, 0, 0, 6);   expect_quiet("R7");
                issue(1, 1, K_BR, 0, 0, 0, 7);   expect_quiet("R7");
                issue(1, 0, K_NOP, 0, 0, 0, 6);  expect_quiet("R7");
                issue(1, 1, K_NOP, 0, 0, 0, 7);  expect_quiet("R7");
            end
        end

        // R8: bubbles carrying disruptive classes change nothing.
        issue(1, 2, K_LD, 0, 1, 33, 2); expect_quiet("R8");
        issue(0, 2, K_OTH, 0, 0, 0, 2); expect_quiet("R8");
        issue(1, 2, K_TST, 1, 0, 0, 2); expect_quiet("R8");
        issue(0, 2, K_LD, 0, 1, 33, 2); expect_quiet("R8");
        issue(1, 2, K_BR, 0, 0, 0, 2);  expect_quiet("R8");
        issue(0, 2, K_TST, 9, 0, 0, 2); expect_quiet("R8");
        issue(1, 2, K_NOP, 0, 0, 0, 2); expect_quiet("R8");
        issue(0, 2, K_OTH, 0, 0, 0, 2); expect_quiet("R8");
        issue(1, 2, K_LD, 0, 1, 33, 2); expect_req("R8", 2, 1, 33, 2);

        // R9: disabled context completes silently and its counter clears.
        ctx_en = 4'b1011;
        issue(1, 2, K_LD, 0, 6, 55, 2); expect_quiet("R9");
        tail(2, 6, "R9");
        issue(1, 2, K_LD, 0, 6, 55, 2); expect_quiet("R9");
        ctx_en = 4'b1111;
        tail(2, 6, "R9");
        issue(1, 2, K_LD, 0, 6, 55, 2); expect_quiet("R9");
        tail(2, 6, "R9");
        issue(1, 2, K_LD, 0, 6, 55, 2); expect_req("R9", 2, 6, 55, 2);

        issue(0, 0, K_OTH, 0, 0, 0, 0); expect_quiet("R6");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule